// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block presents a two-address byte interface through which a host programs a small configuration space. Offset 0 carries both the unlock/lock keys and the register index, and offset 1 is a data window onto the register that the index selects. After reset the block is locked. Writing the unlock key moves it into configuration mode, and writing the lock key returns it to the locked state.

The configuration space has three kinds of register. A device-select register picks one of several banked logical devices. Two read-only bytes return a chip identifier and a revision. A pair of index locations give access to the 16-bit I/O base address of the currently selected device. Each bank's base address is driven continuously to the rest of the chip. A bank also drives an enable line, which is high when its base is nonzero. The runtime device, number 0x0A, additionally decodes a 256-byte window starting at its base, and the block reports when a supplied bus address falls inside that window.

Top module: `cfg_port`

## Requirements
- R1: After reset the block is locked, every bank base is 0x0000, all enables are low and the index is 0x00.
- R2: When locked, a read at offset 0 or offset 1 returns 0xFF. Any write other than 0x55 to offset 0 leaves every output and every register unchanged.
- R3: Writing 0x55 to offset 0 unlocks the block. When unlocked, writing 0xAA to offset 0 locks it again, and that write does not change the index.
- R4: When unlocked, any other write to offset 0 loads the index. A read at offset 0 returns the current index.
- R5: Index 0x07 is a read/write device-select byte. Index 0x20 reads the ID parameter, which must be 0x7C, 0x7D or 0x7F, and index 0x21 reads the revision parameter. Writes to 0x20 and 0x21 have no effect. Unused indices read 0x00.
- R6: Index 0x60 holds the high byte and index 0x61 the low byte of the selected device's base. A bank is reached only when the device-select value equals that bank's device number. When no bank matches, these indices read 0x00 and writes to them are ignored.
- R7: Banks are numbered from 0x0A upward: bank k serves device 0x0A+k. Each bank's base and enable appear at the outputs, and the enable is high exactly when the base is nonzero.
- R8: rt_hit is high when rt_en is high and probe_addr[15:8] equals the high byte of the runtime base. Its value depends on probe_addr combinationally.
- R9: Read data is combinational from addr and the current state. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Port offset (0 = index, 1 = data) |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| dev_base | output | 16*NDEV | Base address of each bank, bank 0 in the low bits |
| dev_en | output | NDEV | Enable of each bank |
| probe_addr | input | 16 | Address compared against the runtime window |
| rt_hit | output | 1 | probe_addr falls in the runtime 256-byte window |

## Verification
A wrong lock state shows up on the next read of either port, which returns 0xFF instead of the index or the register contents, or the reverse. A device-select value steered to the wrong bank shows up on the very next edge, because the base write then changes a different slice of dev_base. That misdirection is visible on the outputs, not only when the register is read back. A stuck enable or a wrong window compare appears combinationally on dev_en and rt_hit as soon as the base changes.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int NDEV = 4,
  parameter logic [7:0] CHIP_ID = 8'h7C,
  parameter logic [7:0] CHIP_REV = 8'h01,
  parameter logic [7:0] KEY_ON = 8'h55,
  parameter logic [7:0] KEY_OFF = 8'hAA,
  parameter logic [7:0] DEV0 = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [16*NDEV-1:0] dev_base,
  output logic [NDEV-1:0]   dev_en,
  input  logic [15:0]       probe_addr,
  output logic              rt_hit
);
  localparam logic [7:0] IX_SEL = 8'h07, IX_ID = 8'h20, IX_REV = 8'h21,
                         IX_HI = 8'h60, IX_LO = 8'h61;

  logic       unlocked;
  logic [7:0] idx, sel;
  logic [15:0] base [NDEV];
  logic [NDEV-1:0] hit;
  logic [7:0] reg_rd;

  wire wr_idx  = wr && !addr;
  wire wr_data = wr && addr && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      idx <= 8'h00;
      sel <= 8'h00;
    end else begin
      if (wr_idx) begin
        if (!unlocked) begin
          if (wdata == KEY_ON) unlocked <= 1'b1;
        end else if (wdata == KEY_OFF) unlocked <= 1'b0;
        else idx <= wdata;
      end
      if (wr_data && idx == IX_SEL) sel <= wdata;
    end
  end

  for (genvar k = 0; k < NDEV; k++) begin : g_bank
    assign hit[k] = (sel == DEV0 + 8'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base[k] <= 16'h0000;
      else if (wr_data && hit[k]) begin
        if (idx == IX_HI) base[k][15:8] <= wdata;
        if (idx == IX_LO) base[k][7:0] <= wdata;
      end
    end
    assign dev_base[16*k +: 16] = base[k];
    assign dev_en[k] = |base[k];
  end

  always_comb begin
    reg_rd = 8'h00;
    case (idx)
      IX_SEL: reg_rd = sel;
      IX_ID:  reg_rd = CHIP_ID;
      IX_REV: reg_rd = CHIP_REV;
      IX_HI, IX_LO:
        for (int k = 0; k < NDEV; k++)
          if (hit[k]) reg_rd = (idx == IX_HI) ? base[k][15:8] : base[k][7:0];
      default: reg_rd = 8'h00;
    endcase
  end

  assign rdata = !unlocked ? 8'hFF : (addr ? reg_rd : idx);
  assign rt_hit = dev_en[0] && (probe_addr[15:8] == base[0][15:8]);

  wire unused_rd = rd;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NDEV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic addr,
  input logic wr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [16*NDEV-1:0] dev_base,
  input logic [NDEV-1:0] dev_en,
  input logic unlocked
);
  AST_LOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> rdata == 8'hFF) else $error("locked read"); // R2
  AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(wr && !addr && wdata == 8'h55)) |=> $stable(dev_base)) else $error("locked write"); // R2
  AST_UNLOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr && !addr && wdata == 8'h55) |=> unlocked) else $error("unlock"); // R3
  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr && !addr && wdata == 8'hAA) |=> !unlocked) else $error("lock"); // R3
  AST_NO_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(dev_base)) else $error("spurious change"); // R9
  AST_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dev_en[0] == (dev_base[15:0] != 16'h0)) else $error("enable"); // R7
endmodule

bind cfg_port cfg_port_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata),
  .rdata(rdata), .dev_base(dev_base), .dev_en(dev_en), .unlocked(unlocked)
);

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
  localparam int NDEV = 4;
  logic clk = 0, rst_n = 0, addr = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0, rdata;
  logic [16*NDEV-1:0] dev_base;
  logic [NDEV-1:0] dev_en;
  logic [15:0] probe_addr = 0;
  logic rt_hit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_port #(.NDEV(NDEV)) u_cfg_port (.clk, .rst_n, .addr, .wr, .rd, .wdata,
    .rdata, .dev_base, .dev_en, .probe_addr, .rt_hit);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_port(logic a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_port(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata; rd = 0;
  endtask

  task automatic cfg_wr(logic [7:0] ix, logic [7:0] d);
    wr_port(0, ix); wr_port(1, d);
  endtask

  task automatic cfg_rd(logic [7:0] ix, output logic [7:0] d);
    wr_port(0, ix); rd_port(1, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 base", dev_base, '0);
    chk("R1 en", dev_en, '0);
    rd_port(0, d); chk("R1 locked", d, 8'hFF);
    wr_port(0, 8'h55);
    rd_port(0, d); chk("R1 idx", d, 8'h00);
    wr_port(0, 8'hAA);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    wr_port(0, 8'h07); wr_port(1, 8'h0A); wr_port(0, 8'h60); wr_port(1, 8'h12);
    chk("R2 base untouched", dev_base, '0);
    rd_port(1, d); chk("R2 data FF", d, 8'hFF);
    wr_port(0, 8'h55);
    rd_port(0, d); chk("R2 idx untouched", d, 8'h00);
    cfg_rd(8'h07, d); chk("R2 sel untouched", d, 8'h00);
  endtask

  task automatic t_keys;
    logic [7:0] d;
    wr_port(0, 8'h21);
    wr_port(0, 8'hAA);
    rd_port(0, d); chk("R3 lock", d, 8'hFF);
    wr_port(0, 8'h55);
    rd_port(0, d); chk("R3 idx kept", d, 8'h21);
    rd_port(1, d); chk("R4 rev via idx", d, 8'h01);
  endtask

  task automatic t_globals;
    logic [7:0] d;
    cfg_rd(8'h20, d); chk("R5 id", d, 8'h7C);
    cfg_wr(8'h20, 8'h00); cfg_rd(8'h20, d); chk("R5 id ro", d, 8'h7C);
    cfg_rd(8'h33, d); chk("R5 unused", d, 8'h00);
    cfg_wr(8'h07, 8'h5A); cfg_rd(8'h07, d); chk("R5 sel rw", d, 8'h5A);
    cfg_wr(8'h60, 8'h99);
    chk("R6 no bank", dev_base, '0);
    cfg_rd(8'h60, d); chk("R6 no bank read", d, 8'h00);
  endtask

  task automatic t_banks;
    logic [7:0] d;
    cfg_wr(8'h07, 8'h0A); cfg_wr(8'h60, 8'h0A); cfg_wr(8'h61, 8'h00);
    cfg_wr(8'h07, 8'h0C); cfg_wr(8'h61, 8'h78);
    chk("R7 bases", dev_base, {16'h0000, 16'h0078, 16'h0000, 16'h0A00});
    chk("R7 en", dev_en, 4'b0101);
    cfg_rd(8'h61, d); chk("R6 bank2 lo", d, 8'h78);
    cfg_wr(8'h07, 8'h0A); cfg_rd(8'h60, d); chk("R6 bank0 hi", d, 8'h0A);
    cfg_wr(8'h07, 8'h0C); cfg_wr(8'h61, 8'h00);
    chk("R7 en off", dev_en, 4'b0001);
  endtask

  task automatic t_window;
    probe_addr = 16'h0A00; #1 chk("R8 low edge", rt_hit, 1);
    probe_addr = 16'h0AFF; #1 chk("R8 high edge", rt_hit, 1);
    probe_addr = 16'h0B00; #1 chk("R8 past", rt_hit, 0);
    probe_addr = 16'h09FF; #1 chk("R8 below", rt_hit, 0);
  endtask

  task automatic t_timing;
    @(negedge clk); addr = 0; wdata = 8'h21; wr = 1;
    #1 chk("R9 before edge", rdata, 8'h61);
    @(posedge clk); #1 chk("R9 after edge", rdata, 8'h21);
    @(negedge clk); wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_locked; t_keys; t_globals; t_banks; t_window; t_timing;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule